// File: doc/BRIEF.md
# Bus Controller Command List Sequencer

This block walks a linked list of command blocks held in a shared single-port memory and feeds a serial-bus message engine one message at a time. The host loads the address of the first block and pulses `start`. For every block the sequencer reads a control word, acts on its option bits, and reads the command word and the gap length. It then starts the message engine and waits for its done report. It retries a failing message when asked, and marks a final failure in the control word. It waits out the programmed gap and follows the block's link to the next block.

Each block is five 16-bit words at consecutive addresses. Offset 0 is a host-owned back link that the sequencer never touches. Offset 1 is the control word. Offset 2 is the command word for the engine. Offset 3 is the gap in clock cycles, where 0 means no gap. Offset 4 is the address of the next block, and its low `AW` bits are used.

Top module: `cmd_list_seq`

## Requirements
- R1: After reset `busy`, `msgStart`, `memRd`, `memWr`, `stdIrq` and `hpIrq` are all low.
- R2: A `start` pulse while idle loads `startAddr` into the current-block register, seen on `curBlock` one cycle later. After each block that register is loaded with word 4 of that block.
- R3: The sequencer only addresses block offsets 1 to 4. Offset 0 of a block is never read or written.
- R4: Control bit 14 set (skip) means the block's message is not started, no gap is counted and nothing is written back. The sequencer goes straight to the next block.
- R5: Control bit 13 set raises a one-cycle `stdIrq` when the block's control word is read, only if `stdIrqEn` is high. Sequencing goes on without a pause.
- R6: Each message starts with a one-cycle `msgStart`, with `msgCmd` equal to word 2. `msgRtRt` carries control bit 9 and `msgPoll` carries control bit 12.
- R7: If control bit 11 is set and `msgDone` arrives with `msgErr` high, the message is started again, up to `retryLimit` (0 to 3) extra times. Retries stop at the first done without error. With bit 11 clear there is exactly one attempt.
- R8: Only when the last attempt ends with `msgErr` is the block's control word written back to offset 1 with bit 15 set and all other bits unchanged. A successful message writes nothing.
- R9: For a block without end of list whose message succeeds with gap D, `msgStart` of the next executed block comes exactly D+9 cycles after the cycle in which `msgDone` is sampled.
- R10: Control bit 10 set (end of list) halts the sequencer after the block's message. `hpIrq` pulses for one cycle only if `hpIrqEn` is high, and `busy` is low on the following cycle.
- R11: `abort` returns the sequencer to idle on the next cycle, and no further message is started.
- R12: `busy` is high from the cycle after an accepted `start` until the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse from host |
| abort | input | 1 | Return to idle |
| startAddr | input | AW | Address of first block |
| stdIrqEn | input | 1 | Enable for interrupt-and-continue |
| hpIrqEn | input | 1 | Enable for end-of-list interrupt |
| retryLimit | input | 2 | Extra attempts allowed on error |
| memAddr | output | AW | Memory address |
| memRd | output | 1 | Read strobe, data valid next cycle |
| memWr | output | 1 | Write strobe |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data |
| msgStart | output | 1 | Message start pulse |
| msgCmd | output | 16 | Command word for the engine |
| msgRtRt | output | 1 | Terminal-to-terminal transfer flag |
| msgPoll | output | 1 | Polling flag |
| msgDone | input | 1 | Message finished |
| msgErr | input | 1 | Invalid response, valid with msgDone |
| busy | output | 1 | List in progress |
| stdIrq | output | 1 | Interrupt-and-continue pulse |
| hpIrq | output | 1 | End-of-list pulse |
| curBlock | output | AW | Current block address |

## Verification
The assertions assume three things about the inputs. The message engine raises `msgDone` once per `msgStart`. The enables and `retryLimit` are held steady while a list runs. Memory returns read data exactly one cycle after `memRd`. The bench's engine model answers every start after a fixed latency and counts its injected errors from a budget. The bench changes configuration only between runs, when `busy` is low. The memory model is a synchronous array with one-cycle read latency, written by the host only while the sequencer is idle.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CTL_ERR   = 15;
  localparam int CTL_SKIP  = 14;
  localparam int CTL_IRQ   = 13;
  localparam int CTL_POLL  = 12;
  localparam int CTL_RETRY = 11;
  localparam int CTL_EOL   = 10;
  localparam int CTL_RTRT  = 9;

  localparam logic [2:0] OFS_CTL = 3'd1;
  localparam logic [2:0] OFS_CMD = 3'd2;
  localparam logic [2:0] OFS_DLY = 3'd3;
  localparam logic [2:0] OFS_NXT = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_CAP_CTL, S_RD_CMD, S_CAP_CMD, S_RD_DLY, S_CAP_DLY,
    S_MSG_GO, S_MSG_WAIT, S_WR_ERR, S_DELAY, S_RD_NXT, S_CAP_NXT, S_HALT
  } seqState_t;

  typedef struct packed {
    logic       ldStart;
    logic       ldNext;
    logic       ldCtl;
    logic       ldCmd;
    logic       ldDly;
    logic       decDly;
    logic       clrRetry;
    logic       incRetry;
    logic       rd;
    logic       wr;
    logic [2:0] wordSel;
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       abort,
  input  logic       stdIrqEn,
  input  logic       hpIrqEn,
  input  logic       rdSkip,
  input  logic       rdIrq,
  input  logic       ctlEol,
  input  logic       ctlRetry,
  input  logic       dlyZero,
  input  logic       dlyOne,
  input  logic       retryLeft,
  input  logic       msgDone,
  input  logic       msgErr,
  output seqStrobe_t strobe,
  output logic       msgStart,
  output logic       stdIrq,
  output logic       hpIrq,
  output logic       busy
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    msgStart  = 1'b0;
    stdIrq    = 1'b0;
    hpIrq     = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strobe.ldStart = 1'b1;
        nextState      = S_RD_CTL;
      end
      S_RD_CTL: begin
        strobe.rd = 1'b1; strobe.wordSel = OFS_CTL; nextState = S_CAP_CTL;
      end
      S_CAP_CTL: begin
        strobe.ldCtl = 1'b1;
        stdIrq       = rdIrq & stdIrqEn;
        nextState    = rdSkip ? S_RD_NXT : S_RD_CMD;
      end
      S_RD_CMD: begin
        strobe.rd = 1'b1; strobe.wordSel = OFS_CMD; nextState = S_CAP_CMD;
      end
      S_CAP_CMD: begin
        strobe.ldCmd = 1'b1; nextState = S_RD_DLY;
      end
      S_RD_DLY: begin
        strobe.rd = 1'b1; strobe.wordSel = OFS_DLY; nextState = S_CAP_DLY;
      end
      S_CAP_DLY: begin
        strobe.ldDly = 1'b1; strobe.clrRetry = 1'b1; nextState = S_MSG_GO;
      end
      S_MSG_GO: begin
        msgStart = 1'b1; nextState = S_MSG_WAIT;
      end
      S_MSG_WAIT: if (msgDone) begin
        if (msgErr && ctlRetry && retryLeft) begin
          strobe.incRetry = 1'b1;
          nextState       = S_MSG_GO;
        end else if (msgErr) begin
          nextState = S_WR_ERR;
        end else begin
          nextState = ctlEol ? S_HALT : (dlyZero ? S_RD_NXT : S_DELAY);
        end
      end
      S_WR_ERR: begin
        strobe.wr = 1'b1; strobe.wordSel = OFS_CTL;
        nextState = ctlEol ? S_HALT : (dlyZero ? S_RD_NXT : S_DELAY);
      end
      S_DELAY: begin
        strobe.decDly = 1'b1;
        if (dlyOne) nextState = S_RD_NXT;
      end
      S_RD_NXT: begin
        strobe.rd = 1'b1; strobe.wordSel = OFS_NXT; nextState = S_CAP_NXT;
      end
      S_CAP_NXT: begin
        strobe.ldNext = 1'b1; nextState = S_RD_CTL;
      end
      S_HALT: begin
        hpIrq = hpIrqEn; nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    if (abort) begin
      strobe    = '0;
      msgStart  = 1'b0;
      stdIrq    = 1'b0;
      hpIrq     = 1'b0;
      nextState = S_IDLE;
    end
  end
endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int RW = 2
)(
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [AW-1:0] startAddr,
  input  logic [RW-1:0] retryLimit,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] curBlock,
  output logic [DW-1:0] ctlWord,
  output logic [DW-1:0] cmdWord,
  output logic          dlyZero,
  output logic          dlyOne,
  output logic          retryLeft
);
  logic [AW-1:0] curReg;
  logic [DW-1:0] ctlReg, cmdReg, dlyCnt;
  logic [RW-1:0] retryCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curReg   <= '0;
      ctlReg   <= '0;
      cmdReg   <= '0;
      dlyCnt   <= '0;
      retryCnt <= '0;
    end else begin
      if (strobe.ldStart)     curReg <= startAddr;
      else if (strobe.ldNext) curReg <= memRdata[AW-1:0];
      if (strobe.ldCtl) ctlReg <= memRdata;
      if (strobe.ldCmd) cmdReg <= memRdata;
      if (strobe.ldDly)       dlyCnt <= memRdata;
      else if (strobe.decDly) dlyCnt <= dlyCnt - 1'b1;
      if (strobe.clrRetry)      retryCnt <= '0;
      else if (strobe.incRetry) retryCnt <= retryCnt + 1'b1;
    end
  end

  assign memAddr   = curReg + AW'(strobe.wordSel);
  assign memWdata  = ctlReg | (DW'(1) << CTL_ERR);
  assign curBlock  = curReg;
  assign ctlWord   = ctlReg;
  assign cmdWord   = cmdReg;
  assign dlyZero   = (dlyCnt == '0);
  assign dlyOne    = (dlyCnt == DW'(1));
  assign retryLeft = (retryCnt < retryLimit);
endmodule

// File: rtl/cmd_list_seq.sv
module cmd_list_seq
  import seq_pkg::*;
#(
  parameter int AW = 8
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] startAddr,
  input  logic          stdIrqEn,
  input  logic          hpIrqEn,
  input  logic [1:0]    retryLimit,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [15:0]   memWdata,
  input  logic [15:0]   memRdata,
  output logic          msgStart,
  output logic [15:0]   msgCmd,
  output logic          msgRtRt,
  output logic          msgPoll,
  input  logic          msgDone,
  input  logic          msgErr,
  output logic          busy,
  output logic          stdIrq,
  output logic          hpIrq,
  output logic [AW-1:0] curBlock
);
  seqStrobe_t strobe;
  logic [15:0] ctlWord;
  logic dlyZero, dlyOne, retryLeft;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .stdIrqEn(stdIrqEn), .hpIrqEn(hpIrqEn),
    .rdSkip(memRdata[CTL_SKIP]), .rdIrq(memRdata[CTL_IRQ]),
    .ctlEol(ctlWord[CTL_EOL]), .ctlRetry(ctlWord[CTL_RETRY]),
    .dlyZero(dlyZero), .dlyOne(dlyOne), .retryLeft(retryLeft),
    .msgDone(msgDone), .msgErr(msgErr), .strobe(strobe),
    .msgStart(msgStart), .stdIrq(stdIrq), .hpIrq(hpIrq), .busy(busy)
  );

  seq_dp #(.AW(AW), .DW(16), .RW(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .retryLimit(retryLimit), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .curBlock(curBlock), .ctlWord(ctlWord),
    .cmdWord(msgCmd), .dlyZero(dlyZero), .dlyOne(dlyOne),
    .retryLeft(retryLeft)
  );

  assign memRd   = strobe.rd;
  assign memWr   = strobe.wr;
  assign msgRtRt = ctlWord[CTL_RTRT];
  assign msgPoll = ctlWord[CTL_POLL];
endmodule

// File: rtl/cmd_list_seq_chk.sv
module cmd_list_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        abort,
  input logic        stdIrqEn,
  input logic        hpIrqEn,
  input logic        memRd,
  input logic        memWr,
  input logic [15:0] memWdata,
  input logic        msgStart,
  input logic        busy,
  input logic        stdIrq,
  input logic        hpIrq
);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgStart |=> !msgStart);
  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgStart |-> busy);
  // R5
  std_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    stdIrq |-> stdIrqEn);
  // R10
  hp_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    hpIrq |-> hpIrqEn);
  // R10
  hp_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    hpIrq |=> !busy);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> !busy);
  // R8
  wr_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> memWdata[15]);
  // R3
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R12
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

bind cmd_list_seq cmd_list_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .abort(abort),
  .stdIrqEn(stdIrqEn), .hpIrqEn(hpIrqEn), .memRd(memRd), .memWr(memWr),
  .memWdata(memWdata), .msgStart(msgStart), .busy(busy),
  .stdIrq(stdIrq), .hpIrq(hpIrq)
);

// File: tb/sim_cmd_list_seq.sv
`timescale 1ns/1ps
module sim_cmd_list_seq;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic stdIrqEn = 1'b0, hpIrqEn = 1'b0;
  logic [1:0] retryLimit = '0;
  logic [AW-1:0] memAddr;
  logic memRd, memWr;
  logic [15:0] memWdata, memRdata;
  logic msgStart, msgRtRt, msgPoll;
  logic [15:0] msgCmd;
  logic msgDone = 1'b0, msgErr = 1'b0;
  logic busy, stdIrq, hpIrq;
  logic [AW-1:0] curBlock;

  always #2.5 clk = ~clk;

  cmd_list_seq #(.AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .startAddr(startAddr), .stdIrqEn(stdIrqEn), .hpIrqEn(hpIrqEn),
    .retryLimit(retryLimit), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata),
    .msgStart(msgStart), .msgCmd(msgCmd), .msgRtRt(msgRtRt),
    .msgPoll(msgPoll), .msgDone(msgDone), .msgErr(msgErr), .busy(busy),
    .stdIrq(stdIrq), .hpIrq(hpIrq), .curBlock(curBlock)
  );

  // memory model with host write port
  logic [15:0] mem [0:(1<<AW)-1];
  logic hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [15:0] hostData = '0;
  logic [15:0] rdq = '0;
  always @(posedge clk) begin
    if (hostWe) mem[hostAddr] <= hostData;
    else if (memWr) mem[memAddr] <= memWdata;
    rdq <= mem[memAddr];
  end
  assign memRdata = rdq;

  // engine model and monitors
  int cyc = 0;
  logic clrMon = 1'b0;
  int errBudget = 0;
  int errUsed = 0, engCnt = 0, startCnt = 0;
  int stdCnt = 0, hpCnt = 0, headHits = 0;
  int startCyc [0:15];
  int doneCyc [0:15];
  logic [15:0] cmdLog [0:15];
  logic rtLog [0:15];
  logic pollLog [0:15];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    msgDone <= 1'b0;
    msgErr  <= 1'b0;
    if (clrMon) begin
      errUsed <= 0; engCnt <= 0; startCnt <= 0;
      stdCnt <= 0; hpCnt <= 0; headHits <= 0;
    end else begin
      if (stdIrq) stdCnt <= stdCnt + 1;
      if (hpIrq) hpCnt <= hpCnt + 1;
      if ((memRd || memWr) && memAddr[3:0] == 4'd0) headHits <= headHits + 1;
      if (msgStart) begin
        startCyc[startCnt[3:0]] <= cyc;
        cmdLog[startCnt[3:0]]   <= msgCmd;
        rtLog[startCnt[3:0]]    <= msgRtRt;
        pollLog[startCnt[3:0]]  <= msgPoll;
        startCnt <= startCnt + 1;
        engCnt   <= 3;
      end else if (engCnt != 0) begin
        engCnt <= engCnt - 1;
        if (engCnt == 1) begin
          msgDone <= 1'b1;
          if (errUsed < errBudget) begin
            msgErr  <= 1'b1;
            errUsed <= errUsed + 1;
          end
          doneCyc[startCnt[3:0] - 4'd1] <= cyc + 1;
        end
      end
    end
  end

  int testCnt = 0, failCnt = 0;

  task automatic chk(string req, int act, int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(int a, int d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = AW'(a); hostData = 16'(d);
    @(posedge clk);
    #1 hostWe = 1'b0;
  endtask

  task automatic putBlock(int base, int ctl, int cmd, int dly, int nxt);
    hostWrite(base, 16'hDEAD);
    hostWrite(base + 1, ctl);
    hostWrite(base + 2, cmd);
    hostWrite(base + 3, dly);
    hostWrite(base + 4, nxt);
  endtask

  task automatic clearMon();
    @(negedge clk); clrMon = 1'b1;
    @(negedge clk); clrMon = 1'b0;
  endtask

  task automatic runList(int addr);
    @(negedge clk); startAddr = AW'(addr); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R12 busy after start", int'(busy), 1);
    chk("R2 curBlock loaded", int'(curBlock), addr);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 msgStart", int'(msgStart), 0);
    chk("R1 mem strobes", int'(memRd | memWr), 0);
    chk("R1 irqs", int'(stdIrq | hpIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(busy), 0);

    // main list: three blocks, last one ends the list
    putBlock(16'h10, 16'h0200, 16'h1111, 5, 16'h20);
    putBlock(16'h20, 16'h3000, 16'h2222, 0, 16'h40);
    putBlock(16'h40, 16'h0400, 16'h3333, 2, 16'h00);
    stdIrqEn = 1'b1; hpIrqEn = 1'b1; retryLimit = 2'd0; errBudget = 0;
    clearMon();
    runList(16'h10);
    chk("R10 halted", int'(busy), 0);
    chk("R6 message count", startCnt, 3);
    chk("R6 cmd 0", int'(cmdLog[0]), 16'h1111);
    chk("R6 cmd 1", int'(cmdLog[1]), 16'h2222);
    chk("R6 cmd 2", int'(cmdLog[2]), 16'h3333);
    chk("R6 rtrt flag", int'(rtLog[0]), 1);
    chk("R6 rtrt clear", int'(rtLog[1]), 0);
    chk("R6 poll flag", int'(pollLog[1]), 1);
    chk("R6 poll clear", int'(pollLog[2]), 0);
    chk("R9 gap with delay 5", startCyc[1] - doneCyc[0], 5 + 9);
    chk("R9 gap with delay 0", startCyc[2] - doneCyc[1], 9);
    chk("R5 std irq count", stdCnt, 1);
    chk("R10 hp irq count", hpCnt, 1);
    chk("R2 final curBlock", int'(curBlock), 16'h40);
    chk("R3 head untouched", headHits, 0);
    chk("R3 head word", int'(mem[16'h10]), 16'hDEAD);
    chk("R8 no write on success", int'(mem[16'h21]), 16'h3000);

    // skip block, interrupt disabled, end-of-list interrupt disabled
    putBlock(16'h60, 16'h6000, 16'hAAAA, 7, 16'h70);
    putBlock(16'h70, 16'h2400, 16'hBBBB, 0, 16'h00);
    stdIrqEn = 1'b0; hpIrqEn = 1'b0;
    clearMon();
    runList(16'h60);
    chk("R4 skipped message", startCnt, 1);
    chk("R4 executed cmd", int'(cmdLog[0]), 16'hBBBB);
    chk("R4 skip not written", int'(mem[16'h61]), 16'h6000);
    chk("R5 std irq gated", stdCnt, 0);
    chk("R10 hp irq gated", hpCnt, 0);
    chk("R10 halted without irq", int'(busy), 0);
    chk("R2 followed link", int'(curBlock), 16'h70);

    // retry / error write-back sweep
    hpIrqEn = 1'b1;
    for (int re = 0; re < 2; re++) begin
      for (int lim = 0; lim < 4; lim++) begin
        for (int nerr = 0; nerr < 5; nerr++) begin
          automatic int ctl = 16'h0442 | (re != 0 ? 16'h0800 : 0);
          automatic int expAtt = (re != 0) ? ((nerr < lim ? nerr : lim) + 1) : 1;
          automatic int expWord = ctl | ((nerr >= expAtt) ? 16'h8000 : 0);
          putBlock(16'h80, ctl, 16'h4000 + nerr, 0, 16'h00);
          retryLimit = 2'(lim); errBudget = nerr;
          clearMon();
          runList(16'h80);
          chk("R7 attempt count", startCnt, expAtt);
          chk("R8 control write-back", int'(mem[16'h81]), expWord);
        end
      end
    end

    // abort during the gap of a self-linked block
    putBlock(16'hA0, 16'h0000, 16'h5555, 100, 16'hA0);
    errBudget = 0;
    clearMon();
    @(negedge clk); startAddr = AW'(16'hA0); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R11 idle after abort", int'(busy), 0);
    begin
      automatic int seen = startCnt;
      repeat (150) @(negedge clk);
      chk("R11 no later message", startCnt, seen);
      chk("R11 still idle", int'(busy), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule